// File: doc/BRIEF.md
# Single and Dual Slope PWM Timer

This block is a pulse-width generator with one compare channel. A 16-bit counter steps once for every clock in which the count-enable strobe is high. The counter follows one of two shapes. In single-slope mode it climbs from zero to a programmable ceiling and then drops straight back to zero. In dual-slope mode it climbs to the ceiling and then walks back down to zero. The pin level at each counter position comes from the compare value, the shape and a polarity select. The result is a duty cycle that covers the full range from fully off to fully on.

The ceiling and compare inputs are shadowed. The block takes in new values only in the step that leaves the ceiling. A write in the middle of a period therefore never produces a runt pulse, and the next period, or the falling half in dual-slope mode, uses the new values. An output-enable gates the pin without disturbing the counting. The current count and the direction flag are brought out for the surrounding logic.

Top module: `pwm_timer`

## Requirements
- R1: A synchronous reset drives count to 0, dir_up to 1 and pwm_out to 0, and copies top_in and cmp_in into the active ceiling (TOP) and compare value (CMP). pwm_out stays 0 until the first enabled step.
- R2: With dual_mode=0, each enabled step moves count from c to c+1, and from TOP to 0. One period is therefore TOP+1 steps.
- R3: With dual_mode=0 and invert=0, after each step pwm_out is 1 exactly when count < CMP. If CMP >= TOP the pin is constantly 1, and CMP=0 gives a constantly low pin. High time per period is min(CMP, TOP+1), or TOP+1 when CMP >= TOP.
- R4: With dual_mode=0 and invert=1, pwm_out is 1 exactly when count >= CMP. At count 0 the compare action wins over the zero action, so CMP=0 gives a constant 1.
- R5: With dual_mode=1, count runs 0,1,…,TOP,TOP-1,…,1 and repeats. One period is 2·TOP steps, and TOP is held for a single step.
- R6: dir_up is 1 while climbing and 0 while falling. It becomes 0 in the step that reaches TOP and 1 in the step that reaches 0. It is always 1 when dual_mode=0.
- R7: With dual_mode=1 and invert=0, positions on the climb (0 up to TOP) are high when count < CMP. Positions on the fall (TOP-1 down to 1) are high when count <= CMP. TOP itself is also high when CMP >= TOP. High time per period is 2·min(CMP, TOP), which gives 0%, 33%, 66% and 100% at TOP=3.
- R8: With dual_mode=1 and invert=1, the pin is the complement of R7.
- R9: top_in and cmp_in are loaded only in an enabled step taken from count = TOP. In single-slope mode the whole next period uses the new values. In dual-slope mode the falling half uses the new CMP.
- R10: While cnt_en=0, count, dir_up and the pin level hold their values.
- R11: While out_en=0, pwm_out is 0 and counting continues. When out_en returns to 1, the pin shows the current level again at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count-enable strobe, one step per high clock |
| top_in | input | 16 | Requested ceiling (shadowed) |
| cmp_in | input | 16 | Requested compare value (shadowed) |
| dual_mode | input | 1 | 0 single-slope, 1 dual-slope |
| invert | input | 1 | 0 non-inverting, 1 inverting |
| out_en | input | 1 | Pin enable |
| pwm_out | output | 1 | PWM pin |
| count | output | 16 | Current counter value |
| dir_up | output | 1 | 1 climbing, 0 falling |

## Verification
Two actions can fall in the same step: the return to zero and a compare match, when CMP is 0. A further pair also coincides: reaching the ceiling and a compare match, when CMP equals TOP, and in the wrap step the shadow load together with the first level taken under the new values. Sweeps over every CMP from 0 to TOP+1 at small ceilings in all four mode and polarity combinations provoke these coincidences. A mid-period write provokes the load case. Each is judged per cycle against a position model and per period against an arithmetic high-time count.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int unsigned CNT_W = 16;
  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t cnt;
    logic up;
  } step_t;

  // Counter position after one step
  function automatic step_t next_step(input cnt_t c, input logic up,
                                      input cnt_t top, input logic dual);
    step_t s;
    if (!dual) begin
      s.up  = 1'b1;
      s.cnt = (c >= top) ? '0 : c + 1'b1;
    end else if (up && c >= top) begin
      s.up  = 1'b0;
      s.cnt = (c == '0) ? '0 : c - 1'b1;
    end else if (up) begin
      s.cnt = c + 1'b1;
      s.up  = (s.cnt != top);
    end else begin
      s.cnt = (c == '0) ? c : c - 1'b1;
      s.up  = (c <= cnt_t'(1));
    end
    return s;
  endfunction

  // Single-slope level: compare wins over zero; CMP>=TOP is full on
  function automatic logic level_single(input cnt_t c, input cnt_t cmp,
                                        input cnt_t top, input logic inv);
    if (inv) return (c >= cmp);
    return (cmp >= top) || (c < cmp);
  endfunction

  // Dual-slope level by position and side of the slope
  function automatic logic level_dual(input cnt_t c, input logic asc,
                                      input cnt_t cmp, input cnt_t top,
                                      input logic inv);
    logic lv;
    if (asc) lv = (c < cmp) || (c == top && cmp >= top);
    else     lv = (c <= cmp);
    return lv ^ inv;
  endfunction
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_timer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  cnt_t top_in,
  input  cnt_t cmp_in,
  output cnt_t top_a,
  output cnt_t cmp_a,
  output cnt_t top_n,
  output cnt_t cmp_n
);
  assign top_n = (rst || load) ? top_in : top_a;
  assign cmp_n = (rst || load) ? cmp_in : cmp_a;

  always_ff @(posedge clk) begin
    top_a <= top_n;
    cmp_a <= cmp_n;
  end

  AST_SHADOW_KEEP: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(top_a) && $stable(cmp_a))); // R9
endmodule

// File: rtl/pwm_stepper.sv
module pwm_stepper
  import pwm_timer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic dual,
  input  cnt_t top_a,
  output cnt_t cnt,
  output logic up,
  output logic at_top,
  output cnt_t nxt,
  output logic nxt_asc
);
  step_t s;

  assign s       = next_step(cnt, up, top_a, dual);
  assign at_top  = (cnt >= top_a);
  assign nxt     = s.cnt;
  assign nxt_asc = up || (s.cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (step) begin
      cnt <= s.cnt;
      up  <= s.up;
    end
  end

  AST_HOLD_CNT: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(cnt) && $stable(up))); // R10
  AST_FAST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !dual && cnt == top_a) |=> (cnt == '0)); // R2
  AST_FAST_UP: assert property (@(posedge clk) disable iff (rst)
    (step && !dual) |=> up); // R6
  AST_DUAL_TURN: assert property (@(posedge clk) disable iff (rst)
    (step && dual && up && (cnt + 1'b1) == top_a) |=> (!up && cnt == $past(top_a))); // R5
endmodule

// File: rtl/pwm_level.sv
module pwm_level
  import pwm_timer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic dual,
  input  logic invert,
  input  cnt_t nxt,
  input  logic nxt_asc,
  input  cnt_t top_n,
  input  cnt_t cmp_n,
  output logic pwm_q
);
  logic lv;

  assign lv = dual ? level_dual(nxt, nxt_asc, cmp_n, top_n, invert)
                   : level_single(nxt, cmp_n, top_n, invert);

  always_ff @(posedge clk) begin
    if (rst)       pwm_q <= 1'b0;
    else if (step) pwm_q <= lv;
  end

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(pwm_q)); // R10
  AST_FULL_ON: assert property (@(posedge clk) disable iff (rst)
    (step && !dual && !invert && cmp_n == top_n) |=> pwm_q); // R3
  AST_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
    (step && dual && !invert && cmp_n == '0) |=> !pwm_q); // R7
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] top_in,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic             dual_mode,
  input  logic             invert,
  input  logic             out_en,
  output logic             pwm_out,
  output logic [CNT_W-1:0] count,
  output logic             dir_up
);
  cnt_t top_a, cmp_a, top_n, cmp_n, nxt;
  logic at_top, nxt_asc, load_ev, pwm_q;

  assign load_ev = cnt_en && at_top;

  pwm_shadow u_shadow (
    .clk(clk), .rst(rst), .load(load_ev), .top_in(top_in), .cmp_in(cmp_in),
    .top_a(top_a), .cmp_a(cmp_a), .top_n(top_n), .cmp_n(cmp_n)
  );

  pwm_stepper u_step (
    .clk(clk), .rst(rst), .step(cnt_en), .dual(dual_mode), .top_a(top_a),
    .cnt(count), .up(dir_up), .at_top(at_top), .nxt(nxt), .nxt_asc(nxt_asc)
  );

  pwm_level u_level (
    .clk(clk), .rst(rst), .step(cnt_en), .dual(dual_mode), .invert(invert),
    .nxt(nxt), .nxt_asc(nxt_asc), .top_n(top_n), .cmp_n(cmp_n), .pwm_q(pwm_q)
  );

  assign pwm_out = out_en & pwm_q;

  AST_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
    (!out_en) |-> !pwm_out); // R11
  AST_FALL_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (dual_mode && !dir_up) |-> (count != '0)); // R6
endmodule

// File: tb/sim_pwm_timer.sv
module sim_pwm_timer;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst = 1'b1, cnt_en = 1'b0, dual_mode = 1'b0, invert = 1'b0, out_en = 1'b1;
  logic [W-1:0] top_in = 16'd3, cmp_in = 16'd0;
  wire pwm_out, dir_up;
  wire [W-1:0] count;

  pwm_timer u0 (.clk(clk), .rst(rst), .cnt_en(cnt_en), .top_in(top_in), .cmp_in(cmp_in),
    .dual_mode(dual_mode), .invert(invert), .out_en(out_en), .pwm_out(pwm_out),
    .count(count), .dir_up(dir_up));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int p, T, C, pT, pC;
  bit after;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_level(int c, int pos);
    bit v;
    if (!dual_mode) v = invert ? (c >= C) : ((C >= T) || (c < C));
    else begin
      v = ((pos <= T) ? (c < C) : (c <= C)) || (c == T && C >= T);
      v = v ^ invert;
    end
    return int'(v);
  endfunction

  function automatic int exp_high(int t, int c);
    int h;
    if (!dual_mode) h = invert ? ((c > t) ? 0 : t + 1 - c) : ((c >= t) ? t + 1 : c);
    else begin
      h = 2 * ((c < t) ? c : t);
      if (invert) h = 2 * t - h;
    end
    return h;
  endfunction

  task automatic check_now(string lreq);
    int c, d, e;
    c = dual_mode ? ((p <= T) ? p : 2 * T - p) : p;
    d = dual_mode ? ((p < T) ? 1 : 0) : 1;
    e = after ? exp_level(c, p) : 0;
    e = e & int'(out_en);
    chk(dual_mode ? "R5 count" : "R2 count", int'(count), c);
    chk("R6 dir_up", int'(dir_up), d);
    chk(lreq, int'(pwm_out), e);
  endtask

  task automatic cyc(bit en, string lreq);
    @(negedge clk);
    check_now(lreq);
    top_in = pT[W-1:0];
    cmp_in = pC[W-1:0];
    cnt_en = en;
    if (en) begin
      if (p == T) begin
        C = pC;
        if (!dual_mode) begin T = pT; p = 0; end
        else p = (p + 1) % (2 * T);
      end else if (dual_mode) p = (p + 1) % (2 * T);
      else p = p + 1;
      after = 1;
    end
  endtask

  task automatic do_reset(bit d, bit i, int t, int c);
    @(negedge clk);
    rst = 1; cnt_en = 0; dual_mode = d; invert = i; out_en = 1;
    pT = t; pC = c; top_in = t[W-1:0]; cmp_in = c[W-1:0];
    @(negedge clk);
    rst = 0; p = 0; T = t; C = c; after = 0;
    chk("R1 count", int'(count), 0);
    chk("R1 dir_up", int'(dir_up), 1);
    chk("R1 pwm_out", int'(pwm_out), 0);
  endtask

  function automatic string lvl_req();
    if (dual_mode) return invert ? "R8 level" : "R7 level";
    return invert ? "R4 level" : "R3 level";
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int tops[3] = '{3, 4, 6};
    // Sweeps: all shapes, polarities, ceilings and compare values
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 2; i++)
        for (int ti = 0; ti < 3; ti++)
          for (int c = 0; c <= tops[ti] + 1; c++) begin
            int per, hi;
            do_reset(d[0], i[0], tops[ti], c);
            per = d ? 2 * tops[ti] : tops[ti] + 1;
            hi = 0;
            for (int k = 0; k <= 3 * per; k++) begin
              cyc(1'b1, lvl_req());
              if (k >= per && k < 2 * per) hi += int'(pwm_out);
            end
            chk(d ? (i ? "R8 duty" : "R7 duty") : (i ? "R4 duty" : "R3 duty"),
                hi, exp_high(tops[ti], c));
          end

    // R9: mid-period write in single-slope mode takes effect at the wrap
    do_reset(1'b0, 1'b0, 7, 2);
    for (int k = 0; k < 4; k++) cyc(1'b1, "R9 level");
    pT = 4; pC = 4;
    for (int k = 0; k < 20; k++) cyc(1'b1, "R9 level");

    // R9: dual-slope compare update applies from the falling half
    do_reset(1'b1, 1'b0, 5, 1);
    for (int k = 0; k < 3; k++) cyc(1'b1, "R9 level");
    pC = 4;
    for (int k = 0; k < 24; k++) cyc(1'b1, "R9 level");

    // R10: enable low freezes everything, including at TOP
    do_reset(1'b0, 1'b1, 5, 3);
    for (int k = 0; k < 6; k++) cyc(1'b1, "R10 level");
    pC = 1;
    for (int k = 0; k < 4; k++) cyc(1'b0, "R10 level");
    for (int k = 0; k < 10; k++) cyc(1'b1, "R10 level");
    do_reset(1'b1, 1'b0, 4, 2);
    for (int k = 0; k < 6; k++) cyc(1'b1, "R10 level");
    for (int k = 0; k < 4; k++) cyc(1'b0, "R10 level");
    for (int k = 0; k < 10; k++) cyc(1'b1, "R10 level");

    // R11: gated pin, counting continues
    do_reset(1'b1, 1'b0, 4, 2);
    for (int k = 0; k < 3; k++) cyc(1'b1, "R11 pin");
    out_en = 0;
    for (int k = 0; k < 6; k++) cyc(1'b1, "R11 pin");
    out_en = 1;
    for (int k = 0; k < 8; k++) cyc(1'b1, "R11 pin");

    finish_run();
  end
endmodule